// File: doc/BRIEF.md
# Watermark-Controlled Card Data Buffer

This block is the data staging store of a memory-card host controller. It holds 128 words of 32 bits and sits between a host-side word port and a card-side word stream. The card side is modelled as one word per enabled card clock cycle: `card_clk_en` both gates the card clock and marks a word as moved. In the read direction the card fills the store and the host drains it. In the write direction the host fills it and the card drains it.

Programmable marks decide when each side may act. In the read direction, with the internal DMA mode off, a host request is raised once the fill level exceeds the read mark. At the same time a sticky ready status is set, and that status can optionally drive an interrupt. In the write direction the card stream stays idle until the write mark is reached. Neither side can underrun or overrun the store, because the card clock is stopped instead. A card-side error aborts the transfer and discards the buffered block. After the error the system address output still shows where the abandoned block started.

Top module: `card_data_buffer`

## Requirements
- R1: The store keeps words in first-in first-out order. `level` reports the current fill, from 0 to 128. In the write direction a host write while the store is full is dropped.
- R2: In the read direction with `dma_en` low, `host_req` is high exactly when `level` is strictly greater than `rd_mark`. When `level` equals `rd_mark`, `host_req` is low.
- R3: `rdy_stat` is set one cycle after `host_req` rises and stays set until `rdy_clr` or a soft reset. `irq` is high only while both `rdy_stat` and `rdy_ie` are high.
- R4: In the write direction the card clock stays off until `level` reaches `wr_mark`, which may be any value from 1 to 128. Once that happens, the card stream continues until the transfer ends, even if the level later drops below the mark.
- R5: In the write direction the card clock is off whenever the store is empty, so no word is ever sent from an empty store.
- R6: In the read direction the card clock is off whenever the store is full, so no card word is ever lost.
- R7: If `card_err` is pulsed during a transfer, the transfer ends and the store is emptied. `xfer_err` is then set, and `sys_addr` holds the start address of the block that was abandoned. That address is `base_addr` plus 4 × words-per-block × the number of completed blocks.
- R8: `stop_cmd` pulses for one cycle when the last word of a transfer with more than one block moves, provided `ac_stop_en` is set. It never pulses on an error abort.
- R9: With `dma_en` high, neither `host_req` nor `rdy_stat` is raised. `xfer_done` is set once every word has moved: for reads, after the host has also emptied the store.
- R10: Each block is ceil(`blk_bytes`/4) words, where `blk_bytes` ranges from 1 to 4096. The card clock stops for good after `blk_num` blocks have moved.
- R11: `soft_rst` empties the store and clears `rdy_stat`, `xfer_err`, `xfer_done` and the active transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Data-path soft reset |
| dir_rd | input | 1 | 1 = card to host, 0 = host to card |
| dma_en | input | 1 | Internal DMA mode |
| ac_stop_en | input | 1 | Issue a stop after a multi-block transfer |
| blk_bytes | input | 13 | Block length in bytes (1 to 4096) |
| blk_num | input | 8 | Number of blocks |
| base_addr | input | 32 | Start address of the transfer |
| rd_mark | input | 8 | Read mark (1 to 128) |
| wr_mark | input | 8 | Write mark (1 to 128) |
| rdy_ie | input | 1 | Interrupt enable for the ready status |
| rdy_clr | input | 1 | Clear the ready status |
| start | input | 1 | Begin a transfer |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write word |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | 32 | Word at the head of the store |
| level | output | 8 | Fill level |
| host_req | output | 1 | Host data request |
| rdy_stat | output | 1 | Sticky ready status |
| irq | output | 1 | Ready interrupt |
| xfer_done | output | 1 | DMA-mode transfer complete |
| sys_addr | output | 32 | Start address of the current block |
| xfer_err | output | 1 | Transfer aborted by error |
| card_clk_en | output | 1 | Card clock enable; one word moves per enabled cycle |
| card_rdata | input | 32 | Word from the card |
| card_wdata | output | 32 | Word to the card |
| card_err | input | 1 | Card-side data error |
| stop_cmd | output | 1 | One-cycle stop request |

## Verification
The main risk is the occupancy counter drifting away from the pointers. That fault shows up within a single card cycle: either `card_clk_en` toggles at the wrong fill level, or the scoreboard sees a word out of order on `card_wdata` or `h_rdata`. A wrong block counter shows up as `sys_addr` moving at the wrong word, or as the card clock running past the last block. A ready status that is not sticky, or that is set in DMA mode, is visible on `rdy_stat` one cycle after `host_req` changes.

// File: rtl/card_data_buffer.sv
module card_data_buffer #(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  parameter int LW    = 13,
  parameter int BW    = 8,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          dir_rd,
  input  logic          dma_en,
  input  logic          ac_stop_en,
  input  logic [LW-1:0] blk_bytes,
  input  logic [BW-1:0] blk_num,
  input  logic [AW-1:0] base_addr,
  input  logic [$clog2(DEPTH):0] rd_mark,
  input  logic [$clog2(DEPTH):0] wr_mark,
  input  logic          rdy_ie,
  input  logic          rdy_clr,
  input  logic          start,
  input  logic          h_wr,
  input  logic [DW-1:0] h_wdata,
  input  logic          h_rd,
  output logic [DW-1:0] h_rdata,
  output logic [$clog2(DEPTH):0] level,
  output logic          host_req,
  output logic          rdy_stat,
  output logic          irq,
  output logic          xfer_done,
  output logic [AW-1:0] sys_addr,
  output logic          xfer_err,
  output logic          card_clk_en,
  input  logic [DW-1:0] card_rdata,
  output logic [DW-1:0] card_wdata,
  input  logic          card_err,
  output logic          stop_cmd
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int WW = LW - 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          running, started, drain, req_q;
  logic [WW-1:0] words_left;
  logic [BW-1:0] blks_left;
  logic [LW:0]   blk_sum;
  logic [WW-1:0] blk_words;

  wire full   = cnt == CW'(DEPTH);
  wire empty  = cnt == '0;
  wire tx_go  = started | (cnt >= wr_mark);
  wire abort  = card_err & running;
  wire flush  = soft_rst | abort;
  wire req_c  = dir_rd & ~dma_en & (cnt > rd_mark);

  assign blk_sum     = {1'b0, blk_bytes} + (LW+1)'(3);
  assign blk_words   = blk_sum[LW:2];
  assign card_clk_en = running & (dir_rd ? ~full : (tx_go & ~empty));
  wire push = dir_rd ? card_clk_en : (h_wr & ~full);
  wire pop  = dir_rd ? (h_rd & ~empty) : card_clk_en;

  assign h_rdata    = mem[rp];
  assign card_wdata = mem[rp];
  assign level      = cnt;
  assign host_req   = req_c;
  assign irq        = rdy_stat & rdy_ie;

  always_ff @(posedge clk)
    if (push && !flush) mem[wp] <= dir_rd ? card_rdata : h_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      running <= 0; started <= 0; drain <= 0; req_q <= 0; rdy_stat <= 0;
      xfer_done <= 0; xfer_err <= 0; stop_cmd <= 0;
      words_left <= '0; blks_left <= '0; sys_addr <= '0;
    end else if (soft_rst) begin
      running <= 0; started <= 0; drain <= 0; req_q <= 0; rdy_stat <= 0;
      xfer_done <= 0; xfer_err <= 0; stop_cmd <= 0;
    end else begin
      stop_cmd <= 0;
      req_q    <= req_c;
      if (req_c && !req_q) rdy_stat <= 1;
      else if (rdy_clr)    rdy_stat <= 0;
      if (abort) begin
        running <= 0; started <= 0; drain <= 0; xfer_err <= 1;
      end else if (start && !running && !drain && !xfer_err) begin
        running <= 1; started <= 0; xfer_done <= 0;
        words_left <= blk_words; blks_left <= blk_num; sys_addr <= base_addr;
      end else if (running) begin
        if (!dir_rd && cnt >= wr_mark) started <= 1;
        if (card_clk_en) begin
          if (words_left == WW'(1)) begin
            if (blks_left == BW'(1)) begin
              running  <= 0;
              started  <= 0;
              stop_cmd <= ac_stop_en && (blk_num > BW'(1));
              if (dir_rd) drain <= 1;
              else xfer_done <= dma_en;
            end else begin
              words_left <= blk_words;
              blks_left  <= blks_left - 1'b1;
              sys_addr   <= sys_addr + AW'({blk_words, 2'b00});
            end
          end else words_left <= words_left - 1'b1;
        end
      end else if (drain && empty) begin
        drain <= 0; xfer_done <= dma_en;
      end
    end

  a_r1_bounded_level: assert property (@(posedge clk) disable iff (!rst_n) level <= CW'(DEPTH));
  a_r5_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && level == '0) |-> !card_clk_en);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && level == CW'(DEPTH)) |-> !card_clk_en);
  a_r9_dma_quiet: assert property (@(posedge clk) disable iff (!rst_n) dma_en |-> !host_req);
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_stat && !rdy_clr && !soft_rst) |=> rdy_stat);
  a_r8_no_stop_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (card_err && card_clk_en) |=> !stop_cmd);
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_err && !soft_rst) |=> (xfer_err && $stable(sys_addr)));
endmodule

// File: tb/tb_card_data_buffer.sv
module tb_card_data_buffer;
  logic clk = 0, rst_n = 0, soft_rst = 0, dir_rd = 0, dma_en = 0, ac_stop_en = 0;
  logic [12:0] blk_bytes = 13'd16;
  logic [7:0]  blk_num = 8'd1, rd_mark = 8'd4, wr_mark = 8'd8;
  logic [31:0] base_addr = 0, h_wdata = 0, card_rdata = 32'h0101_0101;
  logic rdy_ie = 0, rdy_clr = 0, start = 0, h_wr = 0, h_rd = 0, card_err = 0;
  logic [31:0] h_rdata, sys_addr, card_wdata;
  logic [7:0]  level;
  logic host_req, rdy_stat, irq, xfer_done, xfer_err, card_clk_en, stop_cmd;

  card_data_buffer dut (.*);

  always #10 clk = ~clk;

  int total = 0, fails = 0, nread = 0, stops = 0;
  bit rx_taken = 0, req_seen = 0;
  logic [31:0] wq[$], rq[$];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [31:0] e;
    if (!dir_rd && card_clk_en) begin
      e = (wq.size() != 0) ? wq.pop_front() : 32'hDEAD_BEEF;
      chk(card_wdata == e, "R1", "card word order", card_wdata, e);
    end
    if (dir_rd && h_rd && level != 0) begin
      e = (rq.size() != 0) ? rq.pop_front() : 32'hDEAD_BEEF;
      chk(h_rdata == e, "R1", "host word order", h_rdata, e);
      nread++;
    end
    if (rx_taken) card_rdata = card_rdata + 32'h0101_0101;
    if (dir_rd && card_clk_en) rq.push_back(card_rdata);
    rx_taken = dir_rd && card_clk_en;
    if (stop_cmd) stops++;
    if (host_req && dma_en) req_seen = 1;
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_start(); @(posedge clk); #1 start = 1; @(posedge clk); #1 start = 0; endtask
  task automatic pulse_srst(); @(posedge clk); #1 soft_rst = 1; @(posedge clk); #1 soft_rst = 0; endtask
  task automatic push_n(int n, logic [31:0] b);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 h_wr = 1; h_wdata = b + i; wq.push_back(b + i);
    end
    @(posedge clk); #1 h_wr = 0;
  endtask
  task automatic read_until(int n);
    for (int g = 0; g < 2000; g++) begin
      @(posedge clk); #1;
      if (nread >= n) break;
      h_rd = (level != 0);
    end
    h_rd = 0;
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit seen4, seen5;
    cyc(2); rst_n = 1; cyc(1);
    chk(level == 0 && !host_req && !rdy_stat && !irq && !card_clk_en && !xfer_done && !xfer_err,
        "R11", "reset state", {level, 24'h0}, 0);

    // write direction, mark 8, one block of 16 words
    dir_rd = 0; wr_mark = 8; blk_bytes = 64; blk_num = 1;
    pulse_start();
    push_n(5, 32'hA000_0000); cyc(1);
    chk(!card_clk_en, "R4", "held below write mark", card_clk_en, 0);
    chk(level == 5, "R1", "fill level", level, 5);
    push_n(3, 32'hA000_0005); cyc(1);
    chk(card_clk_en, "R4", "starts at write mark", card_clk_en, 1);
    cyc(12);
    chk(level == 0 && !card_clk_en, "R5", "stall on empty", card_clk_en, 0);
    push_n(8, 32'hA000_0008); cyc(5);
    chk(wq.size() == 0, "R4", "all words sent after stall", wq.size(), 0);
    push_n(1, 32'hA000_0010); cyc(3);
    chk(!card_clk_en && level == 1, "R10", "stops after block count", level, 1);
    pulse_srst(); wq.delete(); cyc(1);
    chk(level == 0, "R11", "soft reset empties", level, 0);

    // read direction overflow and request marks, 150 words
    dir_rd = 1; rd_mark = 4; rdy_ie = 1; blk_bytes = 600; blk_num = 1; base_addr = 32'h3000;
    pulse_start();
    seen4 = 0; seen5 = 0;
    for (int g = 0; g < 300 && level != 128; g++) begin
      @(negedge clk);
      if (level == 4 && !seen4) begin seen4 = 1; chk(!host_req, "R2", "no req at mark", host_req, 0); end
      if (level == 5 && !seen5) begin seen5 = 1; chk(host_req, "R2", "req above mark", host_req, 1); end
    end
    cyc(3);
    chk(level == 128 && !card_clk_en, "R6", "stall on full", {level, 23'h0, card_clk_en}, 32'h8000_0000);
    chk(rdy_stat && irq, "R3", "ready and irq set", {rdy_stat, irq}, 3);
    @(posedge clk); #1 rdy_clr = 1; @(posedge clk); #1 rdy_clr = 0; cyc(1);
    chk(!rdy_stat && !irq && host_req, "R3", "clear while req high", {rdy_stat, host_req}, 1);
    @(posedge clk); #1 rdy_ie = 0;
    nread = 0; read_until(150); cyc(2);
    chk(rq.size() == 0 && nread == 150, "R1", "all read words matched", nread, 150);
    chk(!xfer_done && !irq, "R9", "no done without dma", xfer_done, 0);

    // DMA read, 3 blocks of 4 words, auto stop
    dma_en = 1; ac_stop_en = 1; blk_bytes = 13; blk_num = 3; rd_mark = 1; stops = 0; req_seen = 0;
    pulse_start(); cyc(1);
    chk(!xfer_done, "R9", "done low at start", xfer_done, 0);
    nread = 0; read_until(12); cyc(2);
    chk(xfer_done, "R9", "done after drain", xfer_done, 1);
    chk(!req_seen && !rdy_stat, "R9", "no request in dma", req_seen, 0);
    chk(stops == 1, "R8", "single stop pulse", stops, 1);
    chk(rq.size() == 0, "R10", "12 words for 13-byte blocks", rq.size(), 0);

    // write error mid transfer
    pulse_srst(); dma_en = 0; dir_rd = 0; wr_mark = 1; blk_bytes = 16; blk_num = 3;
    base_addr = 32'h1000; stops = 0;
    pulse_start(); cyc(1);
    chk(sys_addr == 32'h1000, "R7", "address at start", sys_addr, 32'h1000);
    push_n(6, 32'hB000_0000); cyc(6);
    chk(sys_addr == 32'h1010 && !card_clk_en, "R7", "second block address", sys_addr, 32'h1010);
    @(posedge clk); #1 card_err = 1; @(posedge clk); #1 card_err = 0; cyc(2);
    chk(xfer_err, "R7", "error flag", xfer_err, 1);
    chk(sys_addr == 32'h1010, "R7", "abandoned block address", sys_addr, 32'h1010);
    chk(stops == 0, "R8", "no stop on error", stops, 0);
    push_n(2, 32'hB000_0010); cyc(2);
    chk(level == 2 && !card_clk_en, "R7", "aborted transfer stays idle", level, 2);
    pulse_srst(); wq.delete(); cyc(1);
    chk(level == 0 && !xfer_err, "R11", "soft reset clears error", {level, 23'h0, xfer_err}, 0);

    // read error discards buffered words
    dir_rd = 1; blk_bytes = 40; blk_num = 1; base_addr = 32'h2000; rd_mark = 20;
    pulse_start(); cyc(5);
    chk(level != 0, "R1", "card filling", level, 5);
    @(posedge clk); #1 card_err = 1; @(posedge clk); #1 card_err = 0; cyc(1);
    rq.delete();
    chk(level == 0 && xfer_err, "R7", "block discarded", level, 0);
    chk(sys_addr == 32'h2000, "R7", "first block address", sys_addr, 32'h2000);
    pulse_srst(); cyc(1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule